// File: doc/BRIEF.md
# Banked I/O Register Window Decoder

This block sits between a host I/O bus and a set of 16-bit control registers. It decodes a window of sixteen byte addresses. Three strap pins set where that window lies in host I/O space. The registers do not fit in sixteen bytes, so they are spread over banks. A small bank pointer, kept at the top word of the window, chooses which bank the lower seven words reach. That pointer word answers at the same place whatever bank is active, so the host can always switch banks.

Banks 0 to 3 hold internal registers. The block stores these registers itself, loads them with fixed values on reset, and gives each one a write strobe and a read strobe per byte. Banks 4 to 6 are empty. Bank 7 is passed out on an external register port, so that registers outside the block can share the same window. The host may read or write a byte, a word or a doubleword. The block steers each host data lane onto the correct register byte. A doubleword covers two adjacent words of the same bank.

Top module: `banked_io_decoder`

## Requirements
- R1: An access is accepted (`host_hit`=1) only when `host_addr` with its low four bits cleared equals 0x200 + 0x20 × `ios`. Any other address returns zero read data and changes nothing.
- R2: `host_size` encodes 0 = byte, 1 = word, 2 = doubleword, 3 = reserved. A word must sit at an even offset and a doubleword at a multiple of four. A misaligned or reserved access is not accepted and has no effect.
- R3: Host data lane j (bits 8j+7:8j) maps to window byte offset+j. A byte at an odd offset therefore reads and writes bits 15:8 of its register through lane 0.
- R4: A doubleword at offset o reaches the words at o and o+2 of the same bank in one cycle. The lower word is on lanes 1:0.
- R5: The word at offset 0xE is the bank pointer in every bank. Its bits 2:0 hold the bank and reset to 0. Its other bits ignore writes and read as 0. A write takes effect from the next clock edge.
- R6: A doubleword at offset 0xC puts the word at 0xC on lanes 1:0 and the bank pointer on lanes 3:2.
- R7: Each of banks 0 to 3 holds seven 16-bit registers at offsets 0x0 to 0xC. On reset, register w of bank b holds bits 15:12 = b, bits 11:8 = w and bits 7:0 = 0x5A. Writes take effect at the rising clock edge. Reads return data combinationally in the same cycle.
- R8: While the bank pointer is 4, 5 or 6, accesses below 0xE read zero, raise no register strobe and no external strobe, and change no register.
- R9: While the bank pointer is 7, accesses below 0xE raise `ext_stb`. `ext_we` follows the host write, `ext_off` carries the offset, and `ext_be` marks the host lanes that fall below 0xE. Those lanes read from `ext_rdata`. No internal register changes.
- R10: Register w of bank b has strobe index i = b×7+w. Bits 2i and 2i+1 of `reg_wr_be` and `reg_rd_be` flag its low and high byte during an accepted write or read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ios | input | 3 | Strap value selecting window base |
| host_addr | input | 16 | Host byte address |
| host_size | input | 2 | Access size code |
| host_rd | input | 1 | Host read request |
| host_wr | input | 1 | Host write request |
| host_wdata | input | 32 | Host write data, lane 0 first |
| host_hit | output | 1 | Access accepted by the window |
| host_rdata | output | 32 | Read data, zero outside accepted reads |
| reg_wr_be | output | 56 | Per-register byte write strobes |
| reg_rd_be | output | 56 | Per-register byte read strobes |
| reg_val | output | 448 | Current contents of all internal registers |
| ext_stb | output | 1 | External register access strobe |
| ext_we | output | 1 | External access is a write |
| ext_off | output | 4 | Window offset of the external access |
| ext_be | output | 4 | Host lanes taken by the external port |
| ext_wdata | output | 32 | External write data, host lane order |
| ext_rdata | input | 32 | External read data, host lane order |

## Verification
Some rules are checked by assertions on every cycle. An accepted access enables as many window bytes as its size code gives. The bank pointer changes only after a write that covers its byte. Banks 4 to 6 never raise a strobe. The external strobe appears only in bank 7 and never on more lanes than the host enabled. Register write strobes appear only during host writes. The scenarios must show the things that need stored values and chosen data patterns. These are lane steering at even and odd offsets, doublewords that span a register and the bank pointer, the masking of the pointer's upper bits, the strap-selected bases, and the full set of reset values after both the first and a later reset.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  localparam int BANK_W         = 3;
  localparam int INT_BANKS      = 4;
  localparam int WORDS_PER_BANK = 7;
  localparam int NUM_REGS       = INT_BANKS * WORDS_PER_BANK;
  localparam int WIN_BYTES      = 16;
  localparam int DATA_BYTES     = 4;
  localparam int SEL_BYTE       = 2 * WORDS_PER_BANK;
  localparam logic [BANK_W-1:0] EXT_BANK = 3'd7;

  typedef enum logic [1:0] {
    ACC_BYTE  = 2'd0,
    ACC_WORD  = 2'd1,
    ACC_DWORD = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_size_e;

  // Reset value: bank in [15:12], word index in [11:8], fixed low byte.
  function automatic logic [15:0] reg_default(input int b, input int w);
    return {4'(b), 4'(w), 8'h5A};
  endfunction
endpackage

// File: rtl/iowin_addr_decode.sv
module iowin_addr_decode import iowin_pkg::*; #(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] MAP_BASE   = 16'h0200,
  parameter logic [ADDR_W-1:0] STRAP_STEP = 16'h0020
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic [2:0]            ios,
  input  logic [1:0]            size,
  input  logic                  rd,
  input  logic                  wr,
  output logic                  hit,
  output logic [3:0]            off,
  output logic [DATA_BYTES-1:0] lane_en,
  output logic [WIN_BYTES-1:0]  win_en
);
  logic [ADDR_W-1:0]     base;
  logic                  in_win;
  logic                  aligned;
  logic [DATA_BYTES-1:0] size_mask;
  logic                  unused_base;

  assign base        = MAP_BASE + STRAP_STEP * ADDR_W'(ios);
  assign unused_base = ^base[3:0];

  always_comb begin
    off     = addr[3:0];
    in_win  = (addr[ADDR_W-1:4] == base[ADDR_W-1:4]);
    case (acc_size_e'(size))
      ACC_BYTE:  begin size_mask = 4'b0001; aligned = 1'b1;             end
      ACC_WORD:  begin size_mask = 4'b0011; aligned = ~addr[0];         end
      ACC_DWORD: begin size_mask = 4'b1111; aligned = (addr[1:0] == 2'b00); end
      default:   begin size_mask = 4'b0000; aligned = 1'b0;             end
    endcase
    hit     = in_win && aligned && (rd || wr);
    lane_en = hit ? size_mask : '0;
    win_en  = hit ? (WIN_BYTES'(size_mask) << addr[3:0]) : '0;
  end
endmodule

// File: rtl/iowin_bank_sel.sv
module iowin_bank_sel import iowin_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_val,
  output logic [BANK_W-1:0] bank
);
  logic [BANK_W-1:0] bank_q;
  logic [BANK_W-1:0] bank_d;

  always_comb begin
    bank_d = bank_q;
    if (wr_en) bank_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bank_q <= '0;
    else if (wr_en) bank_q <= bank_d;
  end

  assign bank = bank_q;
endmodule

// File: rtl/iowin_reg_banks.sv
module iowin_reg_banks import iowin_pkg::*; #(
  parameter int NB = INT_BANKS,
  parameter int NW = WORDS_PER_BANK
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BANK_W-1:0]    bank,
  input  logic                 rd,
  input  logic                 wr,
  input  logic [2*NW-1:0]      byte_en,
  input  logic [16*NW-1:0]     wdata,
  output logic [16*NW-1:0]     rdata,
  output logic [2*NB*NW-1:0]   wr_be,
  output logic [2*NB*NW-1:0]   rd_be,
  output logic [16*NB*NW-1:0]  val
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    for (genvar w = 0; w < NW; w++) begin : g_word
      localparam int IDX = b * NW + w;
      logic [1:0]  be;
      logic [15:0] q;
      logic [15:0] d;

      assign be                = (bank == BANK_W'(b)) ? byte_en[2*w +: 2] : 2'b00;
      assign wr_be[2*IDX +: 2] = be & {2{wr}};
      assign rd_be[2*IDX +: 2] = be & {2{rd}};

      always_comb begin
        d = q;
        if (be[0]) d[7:0]  = wdata[16*w +: 8];
        if (be[1]) d[15:8] = wdata[16*w + 8 +: 8];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             q <= reg_default(b, w);
        else if (wr && (|be))   q <= d;
      end

      assign val[16*IDX +: 16] = q;
    end
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NB; b++) begin
      for (int w = 0; w < NW; w++) begin
        if (bank == BANK_W'(b)) rdata[16*w +: 16] = val[16*(b*NW + w) +: 16];
      end
    end
  end
endmodule

// File: rtl/banked_io_decoder.sv
module banked_io_decoder import iowin_pkg::*; #(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] MAP_BASE   = 16'h0200,
  parameter logic [ADDR_W-1:0] STRAP_STEP = 16'h0020
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2:0]                ios,
  input  logic [ADDR_W-1:0]         host_addr,
  input  logic [1:0]                host_size,
  input  logic                      host_rd,
  input  logic                      host_wr,
  input  logic [8*DATA_BYTES-1:0]   host_wdata,
  output logic                      host_hit,
  output logic [8*DATA_BYTES-1:0]   host_rdata,
  output logic [2*NUM_REGS-1:0]     reg_wr_be,
  output logic [2*NUM_REGS-1:0]     reg_rd_be,
  output logic [16*NUM_REGS-1:0]    reg_val,
  output logic                      ext_stb,
  output logic                      ext_we,
  output logic [3:0]                ext_off,
  output logic [DATA_BYTES-1:0]     ext_be,
  output logic [8*DATA_BYTES-1:0]   ext_wdata,
  input  logic [8*DATA_BYTES-1:0]   ext_rdata
);
  localparam int NW        = WORDS_PER_BANK;
  localparam int INT_BYTES = 2 * NW;

  // Reset: asserted at once, released through two flops.
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  logic [3:0]             off;
  logic [DATA_BYTES-1:0]  lane_en;
  logic [WIN_BYTES-1:0]   win_en;
  logic [BANK_W-1:0]      bank;
  logic [8*WIN_BYTES-1:0] win_wdata;
  logic [8*WIN_BYTES-1:0] win_img;
  logic [16*NW-1:0]       int_rdata;
  logic [DATA_BYTES-1:0]  ext_lane;
  logic                   unused_ok;

  iowin_addr_decode #(
    .ADDR_W     (ADDR_W),
    .MAP_BASE   (MAP_BASE),
    .STRAP_STEP (STRAP_STEP)
  ) u_decode (
    .addr    (host_addr),
    .ios     (ios),
    .size    (host_size),
    .rd      (host_rd),
    .wr      (host_wr),
    .hit     (host_hit),
    .off     (off),
    .lane_en (lane_en),
    .win_en  (win_en)
  );

  function automatic logic [1:0] lane_of(input int k, input logic [3:0] o);
    logic [3:0] t;
    t = 4'(k) - o;
    return t[1:0];
  endfunction

  // Host lanes onto window bytes: window byte k takes lane (k - offset).
  always_comb begin
    for (int k = 0; k < WIN_BYTES; k++) begin
      win_wdata[8*k +: 8] = host_wdata[8*lane_of(k, off) +: 8];
    end
  end

  iowin_bank_sel u_bank (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .wr_en  (host_wr && win_en[SEL_BYTE]),
    .wr_val (win_wdata[8*SEL_BYTE +: BANK_W]),
    .bank   (bank)
  );

  iowin_reg_banks #(
    .NB (INT_BANKS),
    .NW (NW)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .bank    (bank),
    .rd      (host_rd),
    .wr      (host_wr),
    .byte_en (win_en[INT_BYTES-1:0]),
    .wdata   (win_wdata[8*INT_BYTES-1:0]),
    .rdata   (int_rdata),
    .wr_be   (reg_wr_be),
    .rd_be   (reg_rd_be),
    .val     (reg_val)
  );

  // Window read image: internal words, bank pointer, upper byte zero.
  always_comb begin
    win_img                    = '0;
    win_img[8*INT_BYTES-1:0]   = int_rdata;
    win_img[8*SEL_BYTE +: 8]   = 8'(bank);
  end

  always_comb begin
    for (int j = 0; j < DATA_BYTES; j++) begin
      ext_lane[j] = lane_en[j] && (bank == EXT_BANK) &&
                    ((off + 4'(j)) < 4'(SEL_BYTE));
    end
  end

  assign ext_stb   = |ext_lane;
  assign ext_we    = host_wr && ext_stb;
  assign ext_be    = ext_lane;
  assign ext_off   = off;
  assign ext_wdata = host_wdata;

  always_comb begin
    host_rdata = '0;
    for (int j = 0; j < DATA_BYTES; j++) begin
      if (host_rd && lane_en[j]) begin
        if (ext_lane[j]) host_rdata[8*j +: 8] = ext_rdata[8*j +: 8];
        else             host_rdata[8*j +: 8] = win_img[8*(off + 4'(j)) +: 8];
      end
    end
  end

  assign unused_ok = ^{win_en[WIN_BYTES-1], win_wdata[8*WIN_BYTES-1:8*SEL_BYTE+BANK_W],
                       win_wdata[8*INT_BYTES +: 0 + 8] & 8'h00};

  // R2
  size_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    host_hit |-> ($countones(win_en) == (1 << host_size)));

  // R5
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bank != $past(bank)) |-> $past(host_wr && win_en[SEL_BYTE]));

  // R8
  empty_bank_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bank inside {3'd4, 3'd5, 3'd6}) |-> (reg_wr_be == '0 && reg_rd_be == '0 && !ext_stb));

  // R9
  ext_route_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ext_stb |-> (bank == EXT_BANK && $countones(ext_be) <= $countones(lane_en)
                 && reg_wr_be == '0));

  // R10
  wr_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_wr_be != '0) |-> (host_wr && host_hit && $countones(reg_wr_be) <= DATA_BYTES));
endmodule

// File: tb/banked_io_decoder_tb.sv
module banked_io_decoder_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [2:0]   ios;
  logic [15:0]  host_addr;
  logic [1:0]   host_size;
  logic         host_rd;
  logic         host_wr;
  logic [31:0]  host_wdata;
  logic         host_hit;
  logic [31:0]  host_rdata;
  logic [55:0]  reg_wr_be;
  logic [55:0]  reg_rd_be;
  logic [447:0] reg_val;
  logic         ext_stb;
  logic         ext_we;
  logic [3:0]   ext_off;
  logic [3:0]   ext_be;
  logic [31:0]  ext_wdata;
  logic [31:0]  ext_rdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic        c_hit, c_ext_stb, c_ext_we;
  logic [3:0]  c_ext_be;
  logic [55:0] c_wr_be;

  always #2 clk = ~clk;

  assign ext_rdata = 32'hC3B2A190 ^ {28'h0, ext_off};

  banked_io_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .ios(ios), .host_addr(host_addr), .host_size(host_size),
    .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata), .host_hit(host_hit),
    .host_rdata(host_rdata), .reg_wr_be(reg_wr_be), .reg_rd_be(reg_rd_be), .reg_val(reg_val),
    .ext_stb(ext_stb), .ext_we(ext_we), .ext_off(ext_off), .ext_be(ext_be),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
  );

  function automatic logic [15:0] base_of(input logic [2:0] s);
    return 16'h0200 + 16'h0020 * {13'h0, s};
  endfunction

  function automatic logic [15:0] dflt(input int b, input int w);
    return 16'((b << 12) | (w << 8) | 8'h5A);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [15:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, output logic [31:0] rdv);
    @(negedge clk);
    host_addr = a; host_size = sz; host_wdata = wd; host_wr = w; host_rd = !w;
    #1;
    rdv = host_rdata; c_hit = host_hit; c_ext_stb = ext_stb; c_ext_we = ext_we;
    c_ext_be = ext_be; c_wr_be = reg_wr_be;
    @(posedge clk); #1;
    host_wr = 1'b0; host_rd = 1'b0;
  endtask

  task automatic wr_at(input logic [3:0] o, input logic [1:0] sz, input logic [31:0] d);
    logic [31:0] dummy;
    acc(1'b1, base_of(ios) + {12'h0, o}, sz, d, dummy);
  endtask

  task automatic rd_at(input logic [3:0] o, input logic [1:0] sz, output logic [31:0] d);
    acc(1'b0, base_of(ios) + {12'h0, o}, sz, 32'h0, d);
  endtask

  task automatic set_bank(input int b);
    wr_at(4'hE, 2'd1, 32'h0000FFF8 | 32'(b));
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_defaults;
    logic [31:0] d;
    rd_at(4'hE, 2'd1, d);
    chk(d == 32'h0, "R5 bank reset", d, 0);
    for (int b = 0; b < 4; b++) begin
      set_bank(b);
      for (int w = 0; w < 7; w++) begin
        rd_at(4'(2*w), 2'd1, d);
        chk(d == {16'h0, dflt(b, w)}, "R7 reset value", d, dflt(b, w));
      end
    end
    set_bank(0);
  endtask

  task automatic t_window;
    logic [31:0] d;
    for (int s = 0; s < 8; s++) begin
      ios = 3'(s);
      set_bank(0);
      rd_at(4'h2, 2'd1, d);
      chk(d == 32'h015A && c_hit, "R1 window base", d, 32'h015A);
      acc(1'b1, base_of(ios) + 16'h0010, 2'd1, 32'h0000DEAD, d);
      chk(!c_hit, "R1 above window", c_hit, 0);
      acc(1'b0, base_of(ios) - 16'h0010, 2'd1, 32'h0, d);
      chk(d == 0 && !c_hit, "R1 below window", d, 0);
    end
    ios = 3'd0;
    rd_at(4'h0, 2'd1, d);
    chk(d == 32'h005A, "R1 write outside ignored", d, 32'h005A);
  endtask

  task automatic t_bank_select;
    logic [31:0] d;
    for (int b = 0; b < 8; b++) begin
      set_bank(b);
      rd_at(4'hE, 2'd1, d);
      chk(d == 32'(b), "R5 bank pointer upper bits", d, b);
    end
    wr_at(4'hE, 2'd0, 32'h000000FA);
    rd_at(4'hE, 2'd0, d);
    chk(d == 32'h2, "R5 byte write of pointer", d, 2);
    set_bank(0);
    wr_at(4'hC, 2'd2, 32'h00031234);
    rd_at(4'hE, 2'd1, d);
    chk(d == 32'h3, "R6 dword reaches pointer", d, 3);
    rd_at(4'hC, 2'd1, d);
    chk(d == 32'h365A, "R6 other bank untouched", d, 32'h365A);
    rd_at(4'hC, 2'd2, d);
    chk(d == 32'h0003365A, "R6 dword read spans pointer", d, 32'h0003365A);
    set_bank(0);
    rd_at(4'hC, 2'd1, d);
    chk(d == 32'h1234, "R6 lower half written", d, 32'h1234);
  endtask

  task automatic t_lanes;
    logic [31:0] d;
    set_bank(1);
    wr_at(4'h2, 2'd0, 32'hFFFFFFAB);
    chk(c_wr_be == (56'h1 << 16), "R10 low byte strobe", c_wr_be, 56'h1 << 16);
    wr_at(4'h3, 2'd0, 32'h000000CD);
    chk(c_wr_be == (56'h1 << 17), "R10 high byte strobe", c_wr_be, 56'h1 << 17);
    rd_at(4'h2, 2'd1, d);
    chk(d == 32'hCDAB, "R3 lane steering word", d, 32'hCDAB);
    rd_at(4'h3, 2'd0, d);
    chk(d == 32'hCD, "R3 odd byte on lane 0", d, 32'hCD);
  endtask

  task automatic t_dword;
    logic [31:0] d;
    set_bank(2);
    wr_at(4'h4, 2'd2, 32'h11223344);
    chk(c_wr_be == (56'hF << 32), "R10 dword strobes", c_wr_be, 56'hF << 32);
    rd_at(4'h4, 2'd1, d);
    chk(d == 32'h3344, "R4 lower word", d, 32'h3344);
    rd_at(4'h6, 2'd1, d);
    chk(d == 32'h1122, "R4 upper word", d, 32'h1122);
    rd_at(4'h4, 2'd2, d);
    chk(d == 32'h11223344, "R4 dword read", d, 32'h11223344);
  endtask

  task automatic t_misalign;
    logic [31:0] d;
    wr_at(4'h5, 2'd1, 32'h0000FFFF);
    chk(!c_hit, "R2 odd word rejected", c_hit, 0);
    rd_at(4'h4, 2'd2, d);
    chk(d == 32'h11223344, "R2 odd word no effect", d, 32'h11223344);
    rd_at(4'h2, 2'd2, d);
    chk(d == 0 && !c_hit, "R2 dword misaligned", d, 0);
    rd_at(4'h0, 2'd3, d);
    chk(d == 0 && !c_hit, "R2 reserved size", d, 0);
  endtask

  task automatic t_empty_banks;
    logic [31:0] d;
    for (int b = 4; b < 7; b++) begin
      set_bank(b);
      wr_at(4'h0, 2'd1, 32'h0000BEEF);
      chk(c_wr_be == 0 && !c_ext_stb, "R8 no strobes", {c_wr_be, 3'b0, c_ext_stb}, 0);
      rd_at(4'h0, 2'd1, d);
      chk(d == 0, "R8 reads zero", d, 0);
    end
    set_bank(0);
    rd_at(4'h0, 2'd1, d);
    chk(d == 32'h005A, "R8 bank 0 untouched", d, 32'h005A);
  endtask

  task automatic t_ext_bank;
    logic [31:0] d;
    set_bank(7);
    rd_at(4'h5, 2'd0, d);
    chk(d == 32'h95, "R9 ext byte read", d, 32'h95);
    chk(c_ext_stb && c_ext_be == 4'b0001, "R9 ext byte lanes", c_ext_be, 4'b0001);
    rd_at(4'hC, 2'd2, d);
    chk(d == 32'h0007A19C, "R9 dword ext plus pointer", d, 32'h0007A19C);
    chk(c_ext_be == 4'b0011, "R9 dword ext lanes", c_ext_be, 4'b0011);
    wr_at(4'h0, 2'd1, 32'h00007777);
    chk(c_ext_stb && c_ext_we && c_ext_be == 4'b0011 && c_wr_be == 0,
        "R9 ext write", {c_ext_stb, c_ext_we, c_ext_be}, 6'b110011);
    rd_at(4'hE, 2'd1, d);
    chk(d == 32'h7 && !c_ext_stb, "R9 pointer not forwarded", d, 7);
    set_bank(0);
    rd_at(4'h0, 2'd1, d);
    chk(d == 32'h005A, "R9 internal untouched", d, 32'h005A);
  endtask

  initial begin
    rst_n = 1'b0; ios = 3'd0; host_addr = '0; host_size = '0;
    host_rd = 1'b0; host_wr = 1'b0; host_wdata = '0;
    do_reset();
    t_defaults();
    t_window();
    t_bank_select();
    t_lanes();
    t_dword();
    t_misalign();
    t_empty_banks();
    t_ext_bank();
    do_reset();
    t_defaults();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule